// File: doc/BRIEF.md
# Coded Reference Clock Divider

This block turns a reference clock into the phase-comparison strobe of a frequency synthesiser. A 5-bit ratio code does not give the divide value as a binary number. The two upper bits pick a base multiplier and the three lower bits pick a power of two. This yields 29 usable ratios between 2 and 448. The other three codes are rejected.

The output is a single-cycle strobe, issued once per division period. Software or a control interface may change the code at any time. The new ratio is adopted only when the running period ends, so the strobe never gets a shortened or stretched cycle. An unusable code leaves the last accepted ratio in force and raises an error flag.

Top module: `refdiv_top`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to its initial state: `fcomp_o` and `code_err_o` are 0, the active ratio becomes 2, and the count restarts.
- R2: With code bits [4:3] = 00 and bits [2:0] = n, the ratio is 2^(n+1), so it ranges from 2 to 256.
- R3: With code bits [4:3] = 01 and n from 1 to 7, the ratio is 5·2^(n-1), so it ranges from 5 to 320.
- R4: With code bits [4:3] = 10 and n from 1 to 7, the ratio is 6·2^(n-1), so it ranges from 6 to 384.
- R5: With code bits [4:3] = 11 and n from 1 to 7, the ratio is 7·2^(n-1), so it ranges from 7 to 448.
- R6: Codes 01000, 10000 and 11000 are unusable. Each sets `code_err_o` to 1 in the cycle after the edge that samples it. Such a code does not change the ratio that is pending or active. `code_err_o` is 0 in the cycle after an edge that samples a usable code.
- R7: A ratio change takes effect only at the end of the current division period. The period that is running completes with the old ratio.
- R8: `fcomp_o` is high for exactly one clock cycle per period. Two successive strobes are exactly the active ratio apart in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_code_i | input | 5 | Ratio selection code |
| fcomp_o | output | 1 | Comparison strobe, one cycle per period |
| code_err_o | output | 1 | Unusable code sampled at the previous edge |

## Verification
The bench walks through all 32 codes and holds each one for more than two periods. This exposes a wrong multiplier or shift, because the strobe spacing would drift away from the model. It also exposes an off-by-one terminal count, which would give periods of ratio±1. Each unusable code is applied on top of a known ratio. A design that decoded an unusable code as a value, for example zero or 4·2^-1, would change or stall the strobe, and the bench would catch it. Codes are also swapped in the middle of long periods. A design that reloads at once would cut the running period short, where the model expects it to finish at the old length.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int SHIFT_W = 3;
    localparam int GRP_W   = 2;
    localparam int CODE_W  = SHIFT_W + GRP_W;
    // largest ratio is 7 << (2**SHIFT_W - 2)
    localparam int RATIO_W = (2 ** SHIFT_W) + 1;

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        logic   legal;
        ratio_t ratio;
    } dec_t;

    function automatic dec_t decode_code(input code_t code);
        dec_t                  d;
        logic [GRP_W-1:0]      grp;
        logic [SHIFT_W-1:0]    sh;
        ratio_t                base;
        grp = code[CODE_W-1:SHIFT_W];
        sh  = code[SHIFT_W-1:0];
        d.legal = 1'b1;
        d.ratio = '0;
        if (grp == '0) begin
            d.ratio = ratio_t'(2) << sh;
        end else if (sh == '0) begin
            d.legal = 1'b0;
        end else begin
            base    = ratio_t'(4) + ratio_t'(grp);
            d.ratio = base << (sh - SHIFT_W'(1));
        end
        return d;
    endfunction

endpackage

// File: rtl/refdiv_decode.sv
module refdiv_decode
    import refdiv_pkg::*;
(
    input  code_t code_i,
    output dec_t  dec_o
);
    always_comb begin
        dec_o = decode_code(code_i);
    end
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
    import refdiv_pkg::*;
#(
    parameter int RESET_RATIO = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  dec_t   dec_i,
    output logic   pulse_o,
    output logic   err_o,
    output logic   term_o,
    output ratio_t active_o
);
    ratio_t cnt_q;
    ratio_t act_q;
    ratio_t pend_q;
    ratio_t next_ratio;

    assign next_ratio = dec_i.legal ? dec_i.ratio : pend_q;
    assign term_o     = (cnt_q == act_q - ratio_t'(1));
    assign active_o   = act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            act_q   <= ratio_t'(RESET_RATIO);
            pend_q  <= ratio_t'(RESET_RATIO);
            pulse_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            pend_q <= next_ratio;
            err_o  <= ~dec_i.legal;
            if (term_o) begin
                cnt_q   <= '0;
                act_q   <= next_ratio;
                pulse_o <= 1'b1;
            end else begin
                cnt_q   <= cnt_q + ratio_t'(1);
                pulse_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
    import refdiv_pkg::*;
#(
    parameter int RESET_RATIO = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] ratio_code_i,
    output logic              fcomp_o,
    output logic              code_err_o
);
    dec_t   dec_w;
    logic   term_w;
    ratio_t active_w;

    refdiv_decode i_decode (
        .code_i (ratio_code_i),
        .dec_o  (dec_w)
    );

    refdiv_counter #(.RESET_RATIO(RESET_RATIO)) i_counter (
        .clk      (clk),
        .rst      (rst),
        .dec_i    (dec_w),
        .pulse_o  (fcomp_o),
        .err_o    (code_err_o),
        .term_o   (term_w),
        .active_o (active_w)
    );
endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker
    import refdiv_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input code_t  code,
    input logic   fcomp,
    input logic   err,
    input logic   term,
    input ratio_t active
);
    // R8: strobe lasts a single cycle
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
        fcomp |=> !fcomp);

    // R8: a strobe follows every terminal count
    a_r8_strobe_after_term: assert property (@(posedge clk) disable iff (rst)
        term |=> fcomp);

    // R7: the active ratio holds between terminal counts
    a_r7_ratio_held: assert property (@(posedge clk) disable iff (rst)
        !term |=> $stable(active));

    // R6: the flag reflects the code sampled one edge earlier
    a_r6_err_tracks_code: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (err == ($past(code[2:0]) == 3'b000 && $past(code[4:3]) != 2'b00)));

    // R2: the active ratio never drops below the smallest usable value
    a_r2_ratio_floor: assert property (@(posedge clk) disable iff (rst)
        active >= ratio_t'(2));
endmodule

bind refdiv_top refdiv_checker i_refdiv_checker (
    .clk    (clk),
    .rst    (rst),
    .code   (ratio_code_i),
    .fcomp  (fcomp_o),
    .err    (code_err_o),
    .term   (term_w),
    .active (active_w)
);

// File: tb/test_refdiv_top.sv
`timescale 1ns/1ps
module test_refdiv_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] code = 5'd0;
    logic       fcomp_o;
    logic       code_err_o;

    int    n_cmp  = 0;
    int    n_bad  = 0;
    int    cycles = 0;
    string req    = "R1";

    // reference model state
    int m_cnt, m_act, m_pend;
    bit m_pulse, m_err;

    always #2.5 clk = ~clk;

    refdiv_top i_refdiv_top (
        .clk          (clk),
        .rst          (rst),
        .ratio_code_i (code),
        .fcomp_o      (fcomp_o),
        .code_err_o   (code_err_o)
    );

    // ratio from the requirement text; 0 marks an unusable code
    function automatic int want_ratio(input logic [4:0] c);
        int hi = int'(c[4:3]);
        int lo = int'(c[2:0]);
        if (hi == 0) return 2 ** (lo + 1);
        if (lo == 0) return 0;
        return (4 + hi) * (2 ** (lo - 1));
    endfunction

    always @(posedge clk) begin
        int r, nxt;
        cycles++;
        if (rst) begin
            m_cnt = 0; m_act = 2; m_pend = 2; m_pulse = 0; m_err = 0;
        end else begin
            r     = want_ratio(code);
            nxt   = (r == 0) ? m_pend : r;
            m_err = (r == 0);
            if (m_cnt == m_act - 1) begin
                m_pulse = 1; m_cnt = 0; m_act = nxt;
            end else begin
                m_pulse = 0; m_cnt++;
            end
            m_pend = nxt;
        end
    end

    always @(negedge clk) begin
        n_cmp++;
        if (fcomp_o !== m_pulse || code_err_o !== m_err) begin
            n_bad++;
            $display("FAIL %s cycle %0d: fcomp=%b err=%b expected fcomp=%b err=%b",
                     req, cycles, fcomp_o, code_err_o, m_pulse, m_err);
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input string tag, input int exp_gap);
        int gap = 0;
        while (fcomp_o !== 1'b1 && gap < 1000) begin @(negedge clk); gap++; end
        gap = 0;
        @(negedge clk);
        gap = 1;
        while (fcomp_o !== 1'b1 && gap < 1000) begin @(negedge clk); gap++; end
        n_cmp++;
        if (gap != exp_gap) begin
            n_bad++;
            $display("FAIL %s strobe spacing: actual %0d expected %0d", tag, gap, exp_gap);
        end
    endtask

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        n_cmp++;
        if (fcomp_o !== 1'b0 || code_err_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset outputs: actual %b%b expected 00", fcomp_o, code_err_o);
        end
        rst = 1'b0;
        run(6);

        // R2 R3 R4 R5 R6: sweep every code
        for (int c = 0; c < 32; c++) begin
            int r;
            code = 5'(c);
            r = want_ratio(code);
            case (c >> 3)
                0: req = "R2";
                1: req = "R3";
                2: req = "R4";
                default: req = "R5";
            endcase
            if (r == 0) req = "R6";
            run((r == 0 ? 40 : 2 * r) + 4);
        end

        // R8: strobe spacing equals the ratio
        req = "R8";
        code = 5'b11111; run(460);
        measure("R8", 448);
        code = 5'b01010; run(20);
        measure("R8", 10);

        // R7: mid-period change from 448 to 2
        req = "R7";
        code = 5'b11111; run(1000);
        run(100);
        code = 5'b00000;
        run(400);

        // R6: unusable code on top of ratio 7 keeps period 7
        req = "R6";
        code = 5'b11001; run(30);
        code = 5'b10000; run(30);
        measure("R6", 7);

        // R1: reset in the middle of a period
        req = "R1";
        code = 5'b11111; run(50);
        rst = 1'b1; run(2); rst = 1'b0;
        code = 5'b00000; run(10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule